// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Readout Controller

This block runs a six-channel, 12-bit serial converter that samples all of its inputs at one instant. A frame request latches a 3-bit channel-count code and a bipolar/unipolar choice, places them on the converter's select and mode pins, and raises a convert-start strobe. It then produces a divided serial clock of sixteen cycles per active channel and captures the converter's serial data. Each channel's 12-bit result comes out as a 13-bit two's-complement value with its channel index and a one-cycle valid strobe.

The controller also handles the converter's power states. A power-down request issues two (nap) or four (sleep) convert-start pulses while the serial clock stays low. A wake request issues one serial-clock pulse. A configurable settling delay, counted in system clocks, is inserted after a change of conversion mode and after a wake-up. Frame requests are accepted only while the controller is idle.

Top module: `adc_frame_ctrl`

## Requirements
- R1: A `start_req` seen while idle, with `bipolar_in` equal to the current `adc_bip`, raises `adc_cnv` in the next cycle and holds it high for `CNV_W` system clocks.
- R2: Codes 0 to 4 on `chan_code` convert code+1 channels. Codes 5, 6 and 7 all convert six channels. `adc_sel` carries the latched code, and one result is delivered per active channel.
- R3: After the convert strobe the serial clock runs exactly 16 cycles per active channel. Each cycle is `SCLK_HALF` clocks low followed by `SCLK_HALF` clocks high. The clock then rests low.
- R4: Within each 16-cycle channel slot, slot positions `FIRST_BIT` to `FIRST_BIT`+11 (default 2 to 13) carry the result MSB first. `adc_sdata` is sampled in the last system clock before each serial-clock rise, and all other positions are ignored.
- R5: `res_valid` is a one-cycle pulse in the cycle where the serial clock rises after the final data bit of a slot. `res_chan` counts 0, 1, … up to N-1 in order.
- R6: In bipolar mode (`adc_bip`=1) the 12-bit code is sign-extended to `res_value`. In unipolar mode it is zero-extended.
- R7: A change of `chan_code` or `bipolar_in`, or a `start_req` or `pd_req`, arriving during a frame has no effect on that frame.
- R8: A frame request whose mode differs from `adc_bip` updates `adc_bip` in the next cycle. `adc_cnv` then rises `ACQ_CYC` clocks later than under R1.
- R9: `pd_req` while idle issues 2 convert pulses (nap, `pd_deep`=0) or 4 (sleep, `pd_deep`=1), each `CNV_W` clocks high and `CNV_W` clocks low, with the serial clock held low. Frame requests are then ignored until a wake.
- R10: `wake_req` while powered down gives one serial-clock pulse (`SCLK_HALF` low, then `SCLK_HALF` high), followed by `ACQ_CYC` clocks during which frame requests are ignored. After that a frame request is accepted.
- R11: `busy` is high from the first convert-strobe cycle of a frame through its last serial-clock cycle, and low otherwise, including during power-down and wake.
- R12: During and just after reset, `adc_cnv`, `adc_sclk`, `busy` and `res_valid` are low, and `adc_sel` and `adc_bip` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Frame request pulse |
| chan_code | input | 3 | Channel-count code for the requested frame |
| bipolar_in | input | 1 | Requested mode: 1 bipolar, 0 unipolar |
| pd_req | input | 1 | Power-down request pulse |
| pd_deep | input | 1 | Power-down depth: 1 sleep, 0 nap |
| wake_req | input | 1 | Wake request pulse |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cnv | output | 1 | Convert-start strobe to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sel | output | 3 | Channel-count select pins |
| adc_bip | output | 1 | Mode pin |
| busy | output | 1 | Frame in progress |
| res_valid | output | 1 | Result strobe |
| res_chan | output | 3 | Channel index of the result |
| res_value | output | 13 | Result, two's complement |

## Verification
Take the accepting clock edge as cycle 0 and let A be 0, or `ACQ_CYC` after a mode change. The strobe then occupies cycles 1+A to A+`CNV_W`. Serial-clock cycle c begins at 1+A+`CNV_W`+2c·`SCLK_HALF`, and the result of channel k is due `SCLK_HALF` cycles into serial cycle 16k+`FIRST_BIT`+11. The bench derives every output's expected value from these offsets and compares all outputs once per clock on the falling edge, so each mismatch points to an exact cycle. Power-down pulses, the wake pulse and the windows in which requests are ignored are laid out cycle by cycle in the same way.

// File: rtl/adcfc_pkg.sv
package adcfc_pkg;

    localparam int unsigned NCH_MAX      = 6;
    localparam int unsigned SLOT_CYC     = 16;
    localparam int unsigned RES_W        = 12;
    localparam int unsigned OUT_W        = RES_W + 1;
    localparam int unsigned CODE_W       = 3;
    localparam int unsigned CHAN_W       = 3;
    localparam int unsigned POS_W        = $clog2(SLOT_CYC);
    localparam int unsigned FRAME_W      = $clog2(NCH_MAX * SLOT_CYC);
    localparam int unsigned NAP_PULSES   = 2;
    localparam int unsigned SLEEP_PULSES = 4;
    localparam int unsigned PULSE_W      = $clog2(SLEEP_PULSES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV,
        ST_SHIFT,
        ST_PDOWN,
        ST_PARKED,
        ST_WAKE
    } seq_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              bip;
    } frame_cfg_t;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [OUT_W-1:0]  value;
    } result_t;

    // Number of channels a select code activates, saturating at the maximum.
    function automatic logic [CHAN_W-1:0] active_channels(input logic [CODE_W-1:0] code);
        if (code >= CODE_W'(NCH_MAX - 1))
            return CHAN_W'(NCH_MAX);
        return CHAN_W'(code) + CHAN_W'(1);
    endfunction

    // Sign- or zero-extension of a raw converter code.
    function automatic logic [OUT_W-1:0] format_result(input logic [RES_W-1:0] raw,
                                                       input logic bip);
        return bip ? {raw[RES_W-1], raw} : {1'b0, raw};
    endfunction

endpackage

// File: rtl/adcfc_sclk_gen.sv
module adcfc_sclk_gen #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic sample_stb,
    output logic cycle_end
);
    localparam int unsigned PERIOD = 2 * HALF;
    localparam int unsigned PW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PW-1:0] PH_SAMPLE = PW'(HALF - 1);
    localparam logic [PW-1:0] PH_RISE   = PW'(HALF);
    localparam logic [PW-1:0] PH_LAST   = PW'(PERIOD - 1);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run)
            phase <= '0;
        else if (phase == PH_LAST)
            phase <= '0;
        else
            phase <= phase + PW'(1);
    end

    assign sclk       = run && (phase >= PH_RISE);
    assign sample_stb = run && (phase == PH_SAMPLE);
    assign cycle_end  = run && (phase == PH_LAST);

    // R4: a data sample is always followed by a serial clock rise
    p_rise_after_sample_r4: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> $rose(sclk));

endmodule

// File: rtl/adcfc_seq.sv
module adcfc_seq
    import adcfc_pkg::*;
#(
    parameter int unsigned CNV_W   = 2,
    parameter int unsigned ACQ_CYC = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic [CODE_W-1:0]  code_in,
    input  logic               bip_in,
    input  logic               pd_req,
    input  logic               pd_deep,
    input  logic               wake_req,
    input  logic               cycle_end,
    output logic               run,
    output logic               cnv,
    output logic               busy,
    output logic               in_shift,
    output frame_cfg_t         cfg,
    output logic [FRAME_W-1:0] bitc
);
    localparam int unsigned TMAX = (ACQ_CYC > 2 * CNV_W) ? ACQ_CYC : 2 * CNV_W;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_ACQ_END  = TW'(ACQ_CYC - 1);
    localparam logic [TW-1:0] T_CNV_END  = TW'(CNV_W - 1);
    localparam logic [TW-1:0] T_PER_END  = TW'(2 * CNV_W - 1);
    localparam logic [TW-1:0] T_HIGH     = TW'(CNV_W);

    seq_state_e          st;
    logic [TW-1:0]       tcnt;
    logic [PULSE_W-1:0]  pcnt;
    logic [PULSE_W-1:0]  pulse_last;
    logic [CHAN_W-1:0]   nch;
    logic                acq_to_frame;
    logic [FRAME_W-1:0]  last_bit;

    // index of the final serial cycle: 16*nch - 1
    assign last_bit = {nch - CHAN_W'(1), {POS_W{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            tcnt         <= '0;
            pcnt         <= '0;
            pulse_last   <= '0;
            bitc         <= '0;
            cfg          <= '0;
            nch          <= CHAN_W'(1);
            acq_to_frame <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    tcnt <= '0;
                    pcnt <= '0;
                    bitc <= '0;
                    if (start_req) begin
                        cfg.code <= code_in;
                        nch      <= active_channels(code_in);
                        if (bip_in != cfg.bip) begin
                            cfg.bip      <= bip_in;
                            acq_to_frame <= 1'b1;
                            st           <= ST_ACQ;
                        end else begin
                            st <= ST_CONV;
                        end
                    end else if (pd_req) begin
                        pulse_last <= pd_deep ? PULSE_W'(SLEEP_PULSES - 1)
                                              : PULSE_W'(NAP_PULSES - 1);
                        st         <= ST_PDOWN;
                    end
                end
                ST_ACQ: begin
                    if (tcnt == T_ACQ_END) begin
                        tcnt <= '0;
                        st   <= acq_to_frame ? ST_CONV : ST_IDLE;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_CONV: begin
                    if (tcnt == T_CNV_END) begin
                        tcnt <= '0;
                        bitc <= '0;
                        st   <= ST_SHIFT;
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_SHIFT: begin
                    if (cycle_end) begin
                        if (bitc == last_bit)
                            st <= ST_IDLE;
                        else
                            bitc <= bitc + FRAME_W'(1);
                    end
                end
                ST_PDOWN: begin
                    if (tcnt == T_PER_END) begin
                        tcnt <= '0;
                        if (pcnt == pulse_last)
                            st <= ST_PARKED;
                        else
                            pcnt <= pcnt + PULSE_W'(1);
                    end else begin
                        tcnt <= tcnt + TW'(1);
                    end
                end
                ST_PARKED: begin
                    if (wake_req)
                        st <= ST_WAKE;
                end
                ST_WAKE: begin
                    if (cycle_end) begin
                        acq_to_frame <= 1'b0;
                        tcnt         <= '0;
                        st           <= ST_ACQ;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign run      = (st == ST_SHIFT) || (st == ST_WAKE);
    assign in_shift = (st == ST_SHIFT);
    assign busy     = (st == ST_CONV) || (st == ST_SHIFT);
    assign cnv      = (st == ST_CONV) || ((st == ST_PDOWN) && (tcnt < T_HIGH));

    // R3: the serial cycle counter never runs past the frame length
    p_frame_bound_r3: assert property (@(posedge clk) disable iff (rst)
        in_shift |-> (bitc <= last_bit));

    // R9: a power-down sequence never drives the serial clock or busy
    p_pdown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PDOWN || st == ST_PARKED) |-> (!run && !busy));

endmodule

// File: rtl/adcfc_deser.sv
module adcfc_deser
    import adcfc_pkg::*;
#(
    parameter int unsigned FIRST_BIT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_shift,
    input  logic               sample_stb,
    input  logic [FRAME_W-1:0] bitc,
    input  logic               sdata,
    input  logic               bip,
    output logic               res_valid,
    output result_t            res
);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(FIRST_BIT);
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(FIRST_BIT + RES_W - 1);

    logic [POS_W-1:0]  pos;
    logic [CHAN_W-1:0] chan;
    logic [RES_W-2:0]  shreg;
    logic              take;

    assign pos  = bitc[POS_W-1:0];
    assign chan = CHAN_W'(bitc[FRAME_W-1:POS_W]);
    assign take = in_shift && sample_stb && (pos >= POS_FIRST) && (pos <= POS_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= 1'b0;
            if (take) begin
                shreg <= {shreg[RES_W-3:0], sdata};
                if (pos == POS_LAST) begin
                    res_valid <= 1'b1;
                    res.chan  <= chan;
                    res.value <= format_result({shreg, sdata}, bip);
                end
            end
        end
    end

    // R5: results are single-cycle strobes
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
    import adcfc_pkg::*;
#(
    parameter int unsigned SCLK_HALF = 2,
    parameter int unsigned CNV_W     = 2,
    parameter int unsigned ACQ_CYC   = 24,
    parameter int unsigned FIRST_BIT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_req,
    input  logic [2:0]  chan_code,
    input  logic        bipolar_in,
    input  logic        pd_req,
    input  logic        pd_deep,
    input  logic        wake_req,
    input  logic        adc_sdata,
    output logic        adc_cnv,
    output logic        adc_sclk,
    output logic [2:0]  adc_sel,
    output logic        adc_bip,
    output logic        busy,
    output logic        res_valid,
    output logic [2:0]  res_chan,
    output logic [12:0] res_value
);
    logic               run;
    logic               sample_stb;
    logic               cycle_end;
    logic               in_shift;
    frame_cfg_t         cfg;
    logic [FRAME_W-1:0] bitc;
    result_t            res;

    adcfc_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .sclk       (adc_sclk),
        .sample_stb (sample_stb),
        .cycle_end  (cycle_end)
    );

    adcfc_seq #(.CNV_W(CNV_W), .ACQ_CYC(ACQ_CYC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .code_in   (chan_code),
        .bip_in    (bipolar_in),
        .pd_req    (pd_req),
        .pd_deep   (pd_deep),
        .wake_req  (wake_req),
        .cycle_end (cycle_end),
        .run       (run),
        .cnv       (adc_cnv),
        .busy      (busy),
        .in_shift  (in_shift),
        .cfg       (cfg),
        .bitc      (bitc)
    );

    adcfc_deser #(.FIRST_BIT(FIRST_BIT)) u_deser (
        .clk        (clk),
        .rst        (rst),
        .in_shift   (in_shift),
        .sample_stb (sample_stb),
        .bitc       (bitc),
        .sdata      (adc_sdata),
        .bip        (cfg.bip),
        .res_valid  (res_valid),
        .res        (res)
    );

    assign adc_sel   = cfg.code;
    assign adc_bip   = cfg.bip;
    assign res_chan  = res.chan;
    assign res_value = res.value;

    // R9: convert strobe and serial clock are never high together
    p_cnv_sclk_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(adc_cnv && adc_sclk));

    // R11: results only appear inside a frame
    p_res_in_frame_r11: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy);

    // R5: channel index stays within the converter's range
    p_chan_range_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_chan < 3'(NCH_MAX)));

    // R7: select pins hold steady through a frame
    p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(adc_sel));

    // R8: mode pin never moves while a frame runs
    p_bip_hold_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(adc_bip));

endmodule

// File: tb/adc_frame_ctrl_tb.sv
module adc_frame_ctrl_tb;
    localparam int H   = 2;
    localparam int CW  = 2;
    localparam int ACQ = 24;
    localparam int FB  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_req = 1'b0;
    logic [2:0]  chan_code = 3'd0;
    logic        bipolar_in = 1'b0;
    logic        pd_req = 1'b0;
    logic        pd_deep = 1'b0;
    logic        wake_req = 1'b0;
    logic        adc_sdata = 1'b0;
    logic        adc_cnv, adc_sclk, adc_bip, busy, res_valid;
    logic [2:0]  adc_sel, res_chan;
    logic [12:0] res_value;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    bit  cur_bip = 0;
    logic [11:0] conv_val [6];

    always #2.5 clk = ~clk;

    adc_frame_ctrl #(.SCLK_HALF(H), .CNV_W(CW), .ACQ_CYC(ACQ), .FIRST_BIT(FB)) u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .chan_code(chan_code),
        .bipolar_in(bipolar_in), .pd_req(pd_req), .pd_deep(pd_deep),
        .wake_req(wake_req), .adc_sdata(adc_sdata), .adc_cnv(adc_cnv),
        .adc_sclk(adc_sclk), .adc_sel(adc_sel), .adc_bip(adc_bip), .busy(busy),
        .res_valid(res_valid), .res_chan(res_chan), .res_value(res_value)
    );

    // Behavioural converter: captures values on a strobe rise, shifts on clock rise.
    logic [11:0] held [6];
    int  mbit = 0;
    logic prev_cnv = 1'b0, prev_sclk = 1'b0;

    function automatic logic model_bit(input int i);
        int ch  = i / 16;
        int pos = i % 16;
        if (ch < 6 && pos >= FB && pos < FB + 12)
            return held[ch][11 - (pos - FB)];
        return (pos % 3) == 0;
    endfunction

    always @(negedge clk) begin
        if (adc_cnv && !prev_cnv) begin
            for (int k = 0; k < 6; k++) held[k] = conv_val[k];
            mbit = 0;
        end else if (adc_sclk && !prev_sclk) begin
            mbit = mbit + 1;
        end
        prev_cnv  = adc_cnv;
        prev_sclk = adc_sclk;
        adc_sdata = model_bit(mbit);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic load(input int a, input int b, input int c,
                        input int d, input int e, input int f);
        conv_val[0] = 12'(a); conv_val[1] = 12'(b); conv_val[2] = 12'(c);
        conv_val[3] = 12'(d); conv_val[4] = 12'(e); conv_val[5] = 12'(f);
    endtask

    task automatic run_frame(input logic [2:0] code, input bit bip, input bit disturb);
        int n   = (code >= 5) ? 6 : int'(code) + 1;
        int a   = (bip != cur_bip) ? ACQ : 0;
        int j1  = 1 + a + CW;
        int fe  = j1 + 16 * n * 2 * H;
        int nres = 0;
        string rc  = (a != 0) ? "R8" : "R1";
        string rs  = disturb ? "R7" : "R2";
        @(negedge clk);
        chan_code = code; bipolar_in = bip; start_req = 1'b1;
        cur_bip = bip;
        for (int j = 1; j <= fe + 2; j++) begin
            bit e_cnv, e_sclk, e_busy, e_valid;
            int e_chan, d;
            @(negedge clk);
            start_req = 1'b0; pd_req = 1'b0;
            if (disturb && j == 5) begin
                chan_code = ~code; bipolar_in = ~bip; start_req = 1'b1; pd_req = 1'b1;
            end
            e_cnv = (j >= 1 + a) && (j < j1);
            e_busy = (j >= 1 + a) && (j < fe);
            e_sclk = 0; e_valid = 0; e_chan = 0;
            if (j >= j1 && j < fe) begin
                d = j - j1;
                e_sclk = (d % (2 * H)) >= H;
                if ((d % (2 * H)) == H && ((d / (2 * H)) % 16) == FB + 11) begin
                    e_valid = 1;
                    e_chan = (d / (2 * H)) / 16;
                end
            end
            chk(adc_cnv == e_cnv, rc, "cnv", int'(adc_cnv), int'(e_cnv));
            chk(adc_sclk == e_sclk, "R3", "sclk", int'(adc_sclk), int'(e_sclk));
            chk(busy == e_busy, "R11", "busy", int'(busy), int'(e_busy));
            chk(res_valid == e_valid, "R5", "res_valid", int'(res_valid), int'(e_valid));
            chk(adc_sel == code, rs, "sel pins", int'(adc_sel), int'(code));
            chk(adc_bip == bip, "R8", "mode pin", int'(adc_bip), int'(bip));
            if (e_valid && res_valid) begin
                int raw = int'(conv_val[e_chan]);
                int ev  = (bip && raw >= 2048) ? raw - 4096 : raw;
                nres++;
                chk(int'(res_chan) == e_chan, "R5", "res_chan", int'(res_chan), e_chan);
                chk(int'($signed(res_value)) == ev, "R6", "res_value (R4 bits)",
                    int'($signed(res_value)), ev);
            end
        end
        chk(nres == n, rs, "result count", nres, n);
        chan_code = code; bipolar_in = bip;
    endtask

    task automatic power_down(input bit deep);
        int np = deep ? 4 : 2;
        int tot = 2 * CW * np;
        int rises = 0;
        bit pc = 0;
        @(negedge clk);
        pd_req = 1'b1; pd_deep = deep;
        for (int j = 1; j <= tot + 30; j++) begin
            bit e_cnv;
            @(negedge clk);
            pd_req = 1'b0; start_req = 1'b0;
            if (j == tot + 5) start_req = 1'b1;
            e_cnv = ((j - 1) < tot) && (((j - 1) % (2 * CW)) < CW);
            if (adc_cnv && !pc) rises++;
            pc = adc_cnv;
            chk(adc_cnv == e_cnv, "R9", "pdown cnv", int'(adc_cnv), int'(e_cnv));
            chk(!adc_sclk, "R9", "pdown sclk", int'(adc_sclk), 0);
            chk(!busy && !res_valid, "R11", "pdown busy/valid", int'(busy), 0);
        end
        chk(rises == np, "R9", "pdown pulse count", rises, np);
    endtask

    task automatic wake_up();
        @(negedge clk);
        wake_req = 1'b1;
        for (int j = 1; j <= 2 * H + ACQ; j++) begin
            bit e_sclk;
            @(negedge clk);
            wake_req = 1'b0; start_req = 1'b0;
            if (j == 2 * H + 3) start_req = 1'b1;
            e_sclk = (j >= 1 + H) && (j <= 2 * H);
            chk(adc_sclk == e_sclk, "R10", "wake sclk", int'(adc_sclk), int'(e_sclk));
            chk(!adc_cnv, "R10", "no cnv while settling", int'(adc_cnv), 0);
            chk(!busy, "R11", "busy while waking", int'(busy), 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        load(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!adc_cnv && !adc_sclk, "R12", "strobes in reset", int'(adc_cnv | adc_sclk), 0);
        chk(!busy && !res_valid, "R12", "busy/valid in reset", int'(busy | res_valid), 0);
        chk(adc_sel == 3'd0 && !adc_bip, "R12", "pins in reset", int'(adc_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!adc_cnv && !adc_sclk && !busy, "R12", "after reset", int'(adc_cnv), 0);

        load(12'hABC, 0, 0, 0, 0, 0);
        run_frame(3'd0, 1'b0, 1'b0);
        load(12'h001, 12'hFFF, 12'h5A5, 0, 0, 0);
        run_frame(3'd2, 1'b0, 1'b0);
        load(12'h800, 12'h7FF, 12'hFFF, 12'h000, 12'h123, 12'hC00);
        run_frame(3'd5, 1'b1, 1'b0);
        load(12'h3C3, 12'h801, 12'h7FE, 12'h0F0, 12'hF0F, 12'h400);
        run_frame(3'd7, 1'b1, 1'b1);
        load(12'hFFF, 12'h800, 12'h555, 12'hAAA, 12'h001, 12'h7FF);
        run_frame(3'd6, 1'b0, 1'b0);
        load(12'h246, 12'h8AC, 12'hE01, 12'h39F, 12'h6D2, 12'h000);
        run_frame(3'd4, 1'b0, 1'b0);

        power_down(1'b0);
        wake_up();
        load(12'h9F1, 12'h0E7, 0, 0, 0, 0);
        run_frame(3'd1, 1'b0, 1'b0);

        power_down(1'b1);
        wake_up();
        load(12'h801, 12'h7F0, 12'hFFE, 12'h010, 0, 0);
        run_frame(3'd3, 1'b1, 1'b0);

        done = 1;
        summary();
        $finish;
    end

endmodule